// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block sits beside the FIFOs of a serial port controller and turns their fill levels and error pulses into interrupt state. It decodes the receive and transmit occupancy counts against two programmable trigger levels into a live status word. Each clock it folds the live flags and any event pulses into a sticky status register, which software clears bit by bit. A mask, built up through a set-only register and cut back through a clear-only register, selects which sticky bits drive a single level-sensitive interrupt line.

Software reaches the block through a one-cycle register write port and a combinational read port. Eight addresses select the mask-enable, mask-disable, mask, sticky status, RX trigger, TX trigger, timeout-length and live status registers. The FIFOs, the serial shifters and the receive timeout counter live elsewhere. Only their counts and single-cycle pulses arrive here.

Top module: `uart_irq_status`

## Requirements
- R1: Live status bit 0 is 1 when the RX count is at or above the RX trigger level. Bit 1 is 1 when the RX count is 0, and bit 2 when the RX count equals DEPTH. Bit 3 is 1 when the TX count is 0, and bit 4 when the TX count equals DEPTH. All other live bits except bit 13 read 0.
- R2: The TX-count-at-or-above-TX-trigger flag appears at live status bit 13. On the next clock edge it sets sticky status bit 10, and never sticky bit 13.
- R3: At every clock edge, live status bits 0 to 4 are ORed into sticky status bits 0 to 4. A set bit stays set after its condition goes away.
- R4: A write to address 0 ORs the written value into the mask. A write to address 1 clears the written 1 bits from the mask. A write to address 2 leaves the mask unchanged.
- R5: A write to address 3 clears each sticky bit written as 1 and leaves every bit written as 0 unchanged.
- R6: The irq output is 1 exactly when some bit is 1 in both the mask and the sticky status.
- R7: A one-cycle pulse on an event input sets its sticky bit at the next edge: overrun bit 5, framing bit 6, parity bit 7, modem status bit 9, TX overflow bit 12.
- R8: A receive-timeout pulse sets sticky bit 8 only while the timeout-length register (address 6) is nonzero.
- R9: While rst_n is low at a clock edge, the mask, the sticky status and the timeout length become 0. Both trigger levels (addresses 4 and 5) become 32.
- R10: When an event or live flag sets a sticky bit in the same cycle as a write that clears it, the bit ends up set.
- R11: Writes to addresses 4 and 5 load the RX and TX trigger levels. The new levels read back and take effect in the live status comparison from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_ovf | input | 1 | Transmit overflow pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| live_status | output | 16 | Live status word |
| sticky_status | output | 16 | Sticky interrupt status word |
| irq_mask | output | 16 | Interrupt mask |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong sticky update shows up on sticky_status one edge after the offending live flag or pulse. An event that is lost or a clear that is ignored is therefore visible in the very next cycle. A misrouted TX trigger flag appears as bit 13 instead of bit 10 in the sticky word during that same cycle. A corrupted mask or trigger register appears on irq, on live_status or on the read port as soon as the first write lands. The directed scenarios start each test from a quiet state, with counts between the thresholds and the sticky register cleared. Any stray set bit is then caught on the following edge.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt status controller.
// Assumes a 16-bit register word; bit positions are fixed by the
// software view and must not move.
package uart_irq_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE  = 3'd0,
        A_DISABLE = 3'd1,
        A_MASK    = 3'd2,
        A_STICKY  = 3'd3,
        A_RXTRIG  = 3'd4,
        A_TXTRIG  = 3'd5,
        A_TIMEOUT = 3'd6,
        A_LIVE    = 3'd7
    } reg_addr_e;

    // live status positions
    localparam int B_RTRIG      = 0;
    localparam int B_REMPTY     = 1;
    localparam int B_RFULL      = 2;
    localparam int B_TEMPTY     = 3;
    localparam int B_TFULL      = 4;
    localparam int B_TTRIG_LIVE = 13;
    localparam int N_FIFO_FLAGS = 5;

    // sticky event positions
    localparam int B_OVR          = 5;
    localparam int B_FRAME        = 6;
    localparam int B_PARITY       = 7;
    localparam int B_TOUT         = 8;
    localparam int B_MODEM        = 9;
    localparam int B_TTRIG_STICKY = 10;
    localparam int B_TXOVF        = 12;

endpackage

// File: rtl/uart_irq_live.sv
// Live status decoder: compares FIFO occupancy counts against full,
// empty and the programmable trigger levels. Pure combinational;
// assumes counts never exceed DEPTH.
module uart_irq_live
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic [CNT_W-1:0]  tx_trig,
    output logic [WORD_W-1:0] live
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // decode each flag into its fixed live position
    always_comb begin
        live                = '0;
        live[B_RTRIG]       = (rx_count >= rx_trig);
        live[B_REMPTY]      = (rx_count == '0);
        live[B_RFULL]       = (rx_count == FULL_CNT);
        live[B_TEMPTY]      = (tx_count == '0);
        live[B_TFULL]       = (tx_count == FULL_CNT);
        live[B_TTRIG_LIVE]  = (tx_count >= tx_trig);
    end

endmodule

// File: rtl/uart_irq_regs.sv
// Software-programmed control registers: interrupt mask (set-only and
// clear-only write paths, direct writes ignored), both trigger levels
// and the timeout length. Assumes one write per cycle.
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int TO_W     = 8,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mask,
    output logic [CNT_W-1:0]  rx_trig,
    output logic [CNT_W-1:0]  tx_trig,
    output logic [TO_W-1:0]   tout_len
);

    // register updates from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            rx_trig  <= CNT_W'(TRIG_RST);
            tx_trig  <= CNT_W'(TRIG_RST);
            tout_len <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_ENABLE:  mask     <= mask | wr_data;
                A_DISABLE: mask     <= mask & ~wr_data;
                A_RXTRIG:  rx_trig  <= wr_data[CNT_W-1:0];
                A_TXTRIG:  tx_trig  <= wr_data[CNT_W-1:0];
                A_TIMEOUT: tout_len <= wr_data[TO_W-1:0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/uart_irq_sticky.sv
// Sticky interrupt status: every cycle ORs the FIFO flags, the remapped
// TX trigger flag and the event pulses in; a write clears 1 bits.
// Setting wins over clearing in the same cycle.
module uart_irq_sticky
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] live,
    input  logic              ev_overrun,
    input  logic              ev_frame,
    input  logic              ev_parity,
    input  logic              ev_timeout,
    input  logic              ev_modem,
    input  logic              ev_tx_ovf,
    input  logic              tout_armed,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] clr_bits,
    output logic [WORD_W-1:0] sticky
);

    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_vec;

    // gather set sources into sticky positions
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < N_FIFO_FLAGS; i++) begin
            set_vec[i] = live[i];
        end
        set_vec[B_TTRIG_STICKY] = live[B_TTRIG_LIVE];
        set_vec[B_OVR]          = ev_overrun;
        set_vec[B_FRAME]        = ev_frame;
        set_vec[B_PARITY]       = ev_parity;
        set_vec[B_TOUT]         = ev_timeout & tout_armed;
        set_vec[B_MODEM]        = ev_modem;
        set_vec[B_TXOVF]        = ev_tx_ovf;
    end

    // clear request only when the sticky register is written
    always_comb clr_vec = clr_en ? clr_bits : '0;

    // sticky update, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/uart_irq_status.sv
// Top of the UART interrupt status controller: ties the live decoder,
// the control registers and the sticky register together, drives the
// level interrupt and the combinational read port.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int TO_W     = 8,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_overrun,
    input  logic              ev_frame,
    input  logic              ev_parity,
    input  logic              ev_timeout,
    input  logic              ev_modem,
    input  logic              ev_tx_ovf,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic [15:0]       live_status,
    output logic [15:0]       sticky_status,
    output logic [15:0]       irq_mask,
    output logic              irq
);

    logic [CNT_W-1:0] rx_trig;
    logic [CNT_W-1:0] tx_trig;
    logic [TO_W-1:0]  tout_len;
    logic             sticky_wr;

    uart_irq_live #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_live (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig),
        .live     (live_status)
    );

    uart_irq_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TO_W(TO_W), .TRIG_RST(TRIG_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mask     (irq_mask),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig),
        .tout_len (tout_len)
    );

    // a write to the sticky address is a clear request
    always_comb sticky_wr = wr_en && (wr_addr == A_STICKY);

    uart_irq_sticky u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (live_status),
        .ev_overrun (ev_overrun),
        .ev_frame   (ev_frame),
        .ev_parity  (ev_parity),
        .ev_timeout (ev_timeout),
        .ev_modem   (ev_modem),
        .ev_tx_ovf  (ev_tx_ovf),
        .tout_armed (tout_len != '0),
        .clr_en     (sticky_wr),
        .clr_bits   (wr_data),
        .sticky     (sticky_status)
    );

    // level interrupt from enabled sticky bits
    always_comb irq = |(irq_mask & sticky_status);

    // read port multiplexer
    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_MASK:    rd_data = irq_mask;
            A_STICKY:  rd_data = sticky_status;
            A_RXTRIG:  rd_data = WORD_W'(rx_trig);
            A_TXTRIG:  rd_data = WORD_W'(tx_trig);
            A_TIMEOUT: rd_data = WORD_W'(tout_len);
            A_LIVE:    rd_data = live_status;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_checker.sv
// Protocol checker for uart_irq_status, attached with bind below.
module uart_irq_checker
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int TO_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  rx_count,
    input logic              ev_overrun,
    input logic              ev_timeout,
    input logic              ev_modem,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [15:0]       wr_data,
    input logic [15:0]       live_status,
    input logic [15:0]       sticky_status,
    input logic [15:0]       irq_mask,
    input logic              irq,
    input logic [TO_W-1:0]   tout_len
);

    logic seen_edge = 1'b0;
    logic prev_rst  = 1'b0;

    // remember whether the previous edge was a reset edge
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        prev_rst  <= !rst_n;
    end

    // R9: state after a reset edge
    always @(posedge clk) begin
        if (seen_edge && prev_rst) begin
            a_reset_clear_r9: assert (sticky_status == '0 && irq_mask == '0);
        end
    end

    p_full_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_status[B_RFULL] |-> (rx_count == CNT_W'(DEPTH)));

    p_ttrig_remap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_status[B_TTRIG_LIVE] |=> sticky_status[B_TTRIG_STICKY]);

    p_live_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live_status[B_RTRIG] |=> sticky_status[B_RTRIG]);

    p_enable_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ENABLE) |=> ((irq_mask & $past(wr_data)) == $past(wr_data)));

    p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DISABLE) |=> ((irq_mask & $past(wr_data)) == '0));

    p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MASK) |=> (irq_mask == $past(irq_mask)));

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_STICKY && wr_data[B_MODEM] && !ev_modem) |=> !sticky_status[B_MODEM]);

    p_irq_needs_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask != '0 && sticky_status != '0));

    p_tout_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_timeout && tout_len == '0 && !sticky_status[B_TOUT]) |=> !sticky_status[B_TOUT]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> sticky_status[B_OVR]);

endmodule

bind uart_irq_status uart_irq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TO_W(TO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_count      (rx_count),
    .ev_overrun    (ev_overrun),
    .ev_timeout    (ev_timeout),
    .ev_modem      (ev_modem),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .live_status   (live_status),
    .sticky_status (sticky_status),
    .irq_mask      (irq_mask),
    .irq           (irq),
    .tout_len      (tout_len)
);

// File: tb/tb_uart_irq_status.sv
// Directed bench for uart_irq_status: one task per scenario.
module tb_uart_irq_status;

    localparam int CLK_P = 10;
    localparam int DEPTH = 64;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] tx_count = '0;
    logic ev_overrun = 0, ev_frame = 0, ev_parity = 0;
    logic ev_timeout = 0, ev_modem = 0, ev_tx_ovf = 0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [15:0]      rd_data, live_status, sticky_status, irq_mask;
    logic             irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_status #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .ev_overrun(ev_overrun), .ev_frame(ev_frame), .ev_parity(ev_parity),
        .ev_timeout(ev_timeout), .ev_modem(ev_modem), .ev_tx_ovf(ev_tx_ovf),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .live_status(live_status),
        .sticky_status(sticky_status), .irq_mask(irq_mask), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            5: ev_overrun = 1'b1;
            6: ev_frame = 1'b1;
            7: ev_parity = 1'b1;
            8: ev_timeout = 1'b1;
            9: ev_modem = 1'b1;
            default: ev_tx_ovf = 1'b1;
        endcase
        @(negedge clk);
        {ev_overrun, ev_frame, ev_parity, ev_timeout, ev_modem, ev_tx_ovf} = '0;
    endtask

    // counts between thresholds, sticky cleared
    task automatic quiet();
        @(negedge clk);
        rx_count = 1; tx_count = 1;
        wr(3'd3, 16'hFFFF);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        #1;
        chk("R9 sticky", sticky_status, 16'h0000);
        chk("R9 mask", irq_mask, 16'h0000);
        chk("R9 irq", {15'd0, irq}, 16'h0000);
        rd(3'd4, v); chk("R9 rx trigger", v, 16'd32);
        rd(3'd5, v); chk("R9 tx trigger", v, 16'd32);
        rd(3'd6, v); chk("R9 timeout", v, 16'd0);
    endtask

    task automatic t_live();
        @(negedge clk); rx_count = 0;  tx_count = 0;  #1;
        chk("R1 both empty", live_status, 16'h000A);
        @(negedge clk); rx_count = 64; tx_count = 64; #1;
        chk("R1/R2 both full", live_status, 16'h2015);
        @(negedge clk); rx_count = 32; tx_count = 31; #1;
        chk("R1 rx at trigger", live_status, 16'h0001);
        @(negedge clk); rx_count = 31; tx_count = 32; #1;
        chk("R2 tx at trigger live bit 13", live_status, 16'h2000);
    endtask

    task automatic t_accumulate();
        quiet();
        chk("R3 quiet sticky", sticky_status, 16'h0000);
        tx_count = 40;
        @(negedge clk); tx_count = 1;
        chk("R2 sticky bit 10", sticky_status, 16'h0400);
        rx_count = 0;
        @(negedge clk); rx_count = 1;
        @(negedge clk);
        chk("R3 rx empty held", sticky_status, 16'h0402);
        chk("R3 live now clear", live_status, 16'h0000);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0102);
        chk("R4 enable", irq_mask, 16'h0102);
        wr(3'd0, 16'h0020);
        chk("R4 enable or", irq_mask, 16'h0122);
        wr(3'd1, 16'h0100);
        chk("R4 disable", irq_mask, 16'h0022);
        wr(3'd2, 16'hFFFF);
        chk("R4 direct write ignored", irq_mask, 16'h0022);
        rd(3'd2, v); chk("R4 readback", v, 16'h0022);
    endtask

    task automatic t_events();
        for (int b = 5; b <= 12; b++) begin
            if (b == 8 || b == 10 || b == 11) continue;
            quiet();
            pulse(b);
            chk($sformatf("R7 event bit %0d", b), sticky_status, 16'(1 << b));
        end
    endtask

    task automatic t_clear();
        quiet();
        pulse(5); pulse(6); pulse(9);
        wr(3'd3, 16'h0020);
        chk("R5 clear one bit", sticky_status, 16'h0240);
        wr(3'd3, 16'h0000);
        chk("R5 zero write no effect", sticky_status, 16'h0240);
    endtask

    task automatic t_timeout();
        quiet();
        pulse(8);
        chk("R8 timeout gated off", sticky_status, 16'h0000);
        wr(3'd6, 16'd5);
        pulse(8);
        chk("R8 timeout armed", sticky_status, 16'h0100);
    endtask

    task automatic t_irq();
        quiet();
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0020);
        chk("R6 no sticky", {15'd0, irq}, 16'h0000);
        pulse(5);
        chk("R6 asserted", {15'd0, irq}, 16'h0001);
        wr(3'd1, 16'h0020);
        chk("R6 masked off", {15'd0, irq}, 16'h0000);
        wr(3'd0, 16'h0020);
        chk("R6 re-enabled", {15'd0, irq}, 16'h0001);
        wr(3'd3, 16'h0020);
        chk("R6 cleared", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_priority();
        quiet();
        @(negedge clk);
        ev_overrun = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h0020;
        @(negedge clk);
        ev_overrun = 1'b0; wr_en = 1'b0;
        chk("R10 set beats clear", sticky_status, 16'h0020);
    endtask

    task automatic t_trigger();
        logic [15:0] v;
        quiet();
        wr(3'd4, 16'd4);
        wr(3'd5, 16'd2);
        rd(3'd4, v); chk("R11 rx trigger readback", v, 16'd4);
        rd(3'd5, v); chk("R11 tx trigger readback", v, 16'd2);
        @(negedge clk); rx_count = 4; tx_count = 2; #1;
        chk("R11 new levels met", live_status, 16'h2001);
        @(negedge clk); rx_count = 3; tx_count = 1; #1;
        chk("R11 just below", live_status, 16'h0000);
    endtask

    initial begin
        rx_count = 1; tx_count = 1;
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_live();
        t_accumulate();
        t_mask();
        t_events();
        t_clear();
        t_timeout();
        t_irq();
        t_priority();
        t_trigger();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule